// File: doc/BRIEF.md
# I/O MMU Context Register Bank

This block is the software-visible register file of a small I/O memory-management unit. It holds up to sixteen translation contexts and one port word per micro-TLB. Each context has translation-enable, interrupt-enable and TLB-flush controls, a 64-bit translation-table base, table-control, bus-control and attribute words, and a fault status register with a captured 64-bit fault address. The translation core reports faults through a fault event input and acknowledges a requested TLB invalidation with a per-context done pulse. A parameter can select a fixed-delay acknowledge instead.

Software reaches the registers over a simple 32-bit bus with one cycle of read latency. Fault flags are cleared by any write to the status register, so writing zero or writing back the value just read both clear them. The captured address is zeroed at the same time, so software must read it before clearing. The block drives a single interrupt line that combines every context.

Top module: `iommu_ctx_regs`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The context control word at offset 0x00 reads back bit 0 (translation enable) and bit 2 (interrupt enable) as written. Bit 1 is the flush flag, and all other bits read zero.
- R3: Writing 1 to control bit 1 sets the flush flag. It then stays set, even if 0 is written to that bit, until the context's `flush_done` pulse arrives. A done pulse while no flush is pending has no effect. When a done pulse and a new flush request arrive in the same cycle, the flag stays set.
- R4: A fault event sets the bits of `fault_kind & 5'b10111` in the status register at offset 0x20: bit 0 translation fault, bit 1 page fault, bit 2 walk abort, bit 4 multiple hit. Bit 3 and bits above 4 always read zero, and an event with no valid bits changes nothing.
- R5: `irq` is high in the cycle after a register update exactly when some context has interrupt enable set and a nonzero status.
- R6: Any write to the status register clears all of its flags, whether the data is zero or the current value. A fault in the same cycle as a clear is kept.
- R7: The fault address of the first fault that sets status from zero is captured: the low word at offset 0x30 and the high word at 0x34. Later faults add their status bits but do not change the address.
- R8: Both fault address words read zero once status has been cleared. Writes to them are ignored.
- R9: Table control (0x08), bus control (0x0C), table base low (0x10), table base high (0x14) and attributes (0x28) are full 32-bit read/write words.
- R10: Context c starts at byte address c*0x40 for c below 8, and at 0x800+(c-8)*0x40 for c from 8 up.
- R11: The control word of micro-TLB n is at 0x300+16n for n below 32, and at 0x600+16(n-32) above that. Its ID word is 8 bytes later and keeps the low 16 bits. The control word keeps bits [7:4] (context select) and bit 0 (enable). Bit 1 (flush request) and all other bits read zero, and writing zero disables the port.
- R12: Reads of addresses that map to no register return zero, and writes to them change nothing.
- R13: Read data appears in the cycle after the request and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| fault_valid | input | 1 | Fault event from the translation core |
| fault_ctx | input | 4 | Context of the fault event |
| fault_kind | input | 5 | Fault flags in status bit positions |
| fault_addr | input | 64 | Faulting I/O virtual address |
| flush_done | input | NUM_CTX | Per-context invalidation complete pulse |
| irq | output | 1 | Combined fault interrupt |

## Verification
A wrong context decode, such as a wrong window jump after context 7, shows up as a bad readback on the next read of that context. A lost or early flush clear shows on the next poll of the control word. Bad fault bookkeeping shows one cycle later in two places: as a wrong `irq` level, and as a fault address that moves or fails to reach zero. A reference model predicts `bus_rdata` and `irq` for every clock, so any divergence is reported in the cycle it first becomes visible at the ports.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

    localparam int BUS_W = 32;
    localparam int ADDR_W = 12;
    localparam logic [4:0] FAULT_MASK = 5'b10111;

    typedef enum logic [3:0] {
        CR_NONE, CR_CTRL, CR_TCR, CR_BUS, CR_TLO, CR_THI,
        CR_STAT, CR_ATTR, CR_FLO, CR_FHI
    } ctx_reg_e;

    typedef enum logic [1:0] {UR_NONE, UR_CTRL, UR_ID} utlb_reg_e;

    typedef struct packed {
        logic      hit_ctx;
        logic [3:0] ctx;
        ctx_reg_e  creg;
        logic      hit_utlb;
        logic [5:0] utlb;
        utlb_reg_e ureg;
    } decode_t;

    function automatic ctx_reg_e ctx_offset(input logic [5:0] off);
        case (off)
            6'h00:   return CR_CTRL;
            6'h08:   return CR_TCR;
            6'h0C:   return CR_BUS;
            6'h10:   return CR_TLO;
            6'h14:   return CR_THI;
            6'h20:   return CR_STAT;
            6'h28:   return CR_ATTR;
            6'h30:   return CR_FLO;
            6'h34:   return CR_FHI;
            default: return CR_NONE;
        endcase
    endfunction

    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a,
                                            input int n_ctx, input int n_utlb);
        decode_t r;
        logic in_ctx;
        logic in_utlb;
        r = '0;
        r.creg = CR_NONE;
        r.ureg = UR_NONE;
        in_ctx = 1'b0;
        in_utlb = 1'b0;
        // first window holds contexts 0..7, second window from 0x800 holds 8..15
        if (a[11:9] == 3'b000) begin
            r.ctx = {1'b0, a[8:6]};
            in_ctx = 1'b1;
        end else if (a[11:9] == 3'b100) begin
            r.ctx = {1'b1, a[8:6]};
            in_ctx = 1'b1;
        end
        if (in_ctx && int'(r.ctx) < n_ctx) begin
            r.creg = ctx_offset(a[5:0]);
            r.hit_ctx = (r.creg != CR_NONE);
        end
        if (a >= 12'h300 && a < 12'h500) begin
            r.utlb = 6'((a - 12'h300) >> 4);
            in_utlb = 1'b1;
        end else if (a >= 12'h600 && a < 12'h800) begin
            r.utlb = 6'((a - 12'h600) >> 4) + 6'd32;
            in_utlb = 1'b1;
        end
        if (in_utlb && int'(r.utlb) < n_utlb) begin
            if (a[3:0] == 4'h0) r.ureg = UR_CTRL;
            else if (a[3:0] == 4'h8) r.ureg = UR_ID;
            r.hit_utlb = (r.ureg != UR_NONE);
        end
        return r;
    endfunction

endpackage

// File: rtl/iommu_ctx_slot.sv
module iommu_ctx_slot
    import iommu_regs_pkg::*;
#(
    parameter bit FLUSH_BY_DONE = 1'b1,
    parameter int FLUSH_CYCLES  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  ctx_reg_e    wr_reg,
    input  logic [31:0] wr_data,
    input  ctx_reg_e    rd_reg,
    output logic [31:0] rd_val,
    input  logic        fault_valid,
    input  logic [4:0]  fault_kind,
    input  logic [63:0] fault_addr,
    input  logic        flush_done,
    output logic        irq_req
);
    localparam int CNT_W = $clog2(FLUSH_CYCLES + 1);

    typedef struct packed {
        logic             en;
        logic             ie;
        logic             flush;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      tcr;
        logic [31:0]      busc;
        logic [31:0]      tlo;
        logic [31:0]      thi;
        logic [31:0]      attr;
        logic [4:0]       stat;
        logic [63:0]      faddr;
    } slot_t;

    slot_t s_d, s_q;
    logic  done_evt;
    logic [4:0] kind;
    logic  stat_wr;

    generate
        if (FLUSH_BY_DONE) begin : g_ext_ack
            assign done_evt = flush_done;
        end else begin : g_timer_ack
            assign done_evt = s_q.flush && (s_q.cnt == CNT_W'(FLUSH_CYCLES - 1));
        end
    endgenerate

    assign kind    = fault_kind & FAULT_MASK;
    assign stat_wr = wr_en && (wr_reg == CR_STAT);

    always_comb begin
        s_d = s_q;
        s_d.cnt = (s_q.flush && !done_evt) ? s_q.cnt + 1'b1 : '0;
        if (done_evt) s_d.flush = 1'b0;
        if (wr_en) begin
            case (wr_reg)
                CR_CTRL: begin
                    s_d.en = wr_data[0];
                    s_d.ie = wr_data[2];
                    if (wr_data[1]) begin
                        s_d.flush = 1'b1;
                        s_d.cnt   = '0;
                    end
                end
                CR_TCR:  s_d.tcr  = wr_data;
                CR_BUS:  s_d.busc = wr_data;
                CR_TLO:  s_d.tlo  = wr_data;
                CR_THI:  s_d.thi  = wr_data;
                CR_ATTR: s_d.attr = wr_data;
                CR_STAT: begin
                    s_d.stat  = '0;
                    s_d.faddr = '0;
                end
                default: ;
            endcase
        end
        if (fault_valid && kind != 5'b0) begin
            if (s_d.stat == 5'b0) s_d.faddr = fault_addr;
            s_d.stat = s_d.stat | kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (rd_reg)
            CR_CTRL: rd_val = {29'b0, s_q.ie, s_q.flush, s_q.en};
            CR_TCR:  rd_val = s_q.tcr;
            CR_BUS:  rd_val = s_q.busc;
            CR_TLO:  rd_val = s_q.tlo;
            CR_THI:  rd_val = s_q.thi;
            CR_STAT: rd_val = {27'b0, s_q.stat};
            CR_ATTR: rd_val = s_q.attr;
            CR_FLO:  rd_val = s_q.faddr[31:0];
            CR_FHI:  rd_val = s_q.faddr[63:32];
            default: rd_val = '0;
        endcase
    end

    assign irq_req = s_q.ie && (s_q.stat != 5'b0);

    // a pending flush survives every cycle without an acknowledge
    assert_flush_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flush && !done_evt) |=> s_q.flush);

    // the first captured address stays while flags remain and no clear arrives
    assert_addr_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stat != 5'b0 && !stat_wr) |=> $stable(s_q.faddr));

    // with no flags pending, the address words must read zero
    assert_addr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.stat == 5'b0) |-> (s_q.faddr == 64'b0));

endmodule

// File: rtl/iommu_utlb_table.sv
module iommu_utlb_table
    import iommu_regs_pkg::*;
#(
    parameter int NUM_UTLB = 48,
    parameter int ID_W     = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  utlb_reg_e   wr_reg,
    input  logic [5:0]  wr_idx,
    input  logic [31:0] wr_data,
    input  utlb_reg_e   rd_reg,
    input  logic [5:0]  rd_idx,
    output logic [31:0] rd_val
);
    typedef struct packed {
        logic [3:0]      ctx;
        logic            en;
        logic [ID_W-1:0] id;
    } port_t;

    port_t [NUM_UTLB-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < NUM_UTLB; i++) begin
            if (wr_en && wr_idx == 6'(i)) begin
                if (wr_reg == UR_CTRL) begin
                    tab_d[i].ctx = wr_data[7:4];
                    tab_d[i].en  = wr_data[0];
                end else if (wr_reg == UR_ID) begin
                    tab_d[i].id = wr_data[ID_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_UTLB; i++) begin
            if (rd_idx == 6'(i)) begin
                if (rd_reg == UR_CTRL) rd_val = {24'b0, tab_q[i].ctx, 3'b0, tab_q[i].en};
                else if (rd_reg == UR_ID) rd_val = 32'(tab_q[i].id);
            end
        end
    end

    // a zero control write leaves the port disabled
    assert_port_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_reg == UR_CTRL && wr_data == 32'b0) |=> !tab_q[$past(wr_idx)].en);

endmodule

// File: rtl/iommu_ctx_regs.sv
module iommu_ctx_regs
    import iommu_regs_pkg::*;
#(
    parameter int NUM_CTX       = 16,
    parameter int NUM_UTLB      = 48,
    parameter int ID_W          = 16,
    parameter bit FLUSH_BY_DONE = 1'b1,
    parameter int FLUSH_CYCLES  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               fault_valid,
    input  logic [3:0]         fault_ctx,
    input  logic [4:0]         fault_kind,
    input  logic [63:0]        fault_addr,
    input  logic [NUM_CTX-1:0] flush_done,
    output logic               irq
);
    typedef struct packed {
        logic [31:0] rdata;
    } top_t;

    top_t t_d, t_q;
    decode_t dec;
    logic [NUM_CTX-1:0][31:0] slot_rd;
    logic [NUM_CTX-1:0]       slot_irq;
    logic [31:0]              utlb_rd;
    logic                     wr_any;
    logic                     rd_any;

    assign dec    = decode_addr(bus_addr, NUM_CTX, NUM_UTLB);
    assign wr_any = bus_req && bus_we;
    assign rd_any = bus_req && !bus_we;

    generate
        for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
            iommu_ctx_slot #(
                .FLUSH_BY_DONE(FLUSH_BY_DONE),
                .FLUSH_CYCLES (FLUSH_CYCLES)
            ) i_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_en      (wr_any && dec.hit_ctx && dec.ctx == 4'(c)),
                .wr_reg     (dec.creg),
                .wr_data    (bus_wdata),
                .rd_reg     (dec.creg),
                .rd_val     (slot_rd[c]),
                .fault_valid(fault_valid && fault_ctx == 4'(c)),
                .fault_kind (fault_kind),
                .fault_addr (fault_addr),
                .flush_done (flush_done[c]),
                .irq_req    (slot_irq[c])
            );
        end
    endgenerate

    iommu_utlb_table #(
        .NUM_UTLB(NUM_UTLB),
        .ID_W    (ID_W)
    ) i_utlb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_any && dec.hit_utlb),
        .wr_reg (dec.ureg),
        .wr_idx (dec.utlb),
        .wr_data(bus_wdata),
        .rd_reg (dec.ureg),
        .rd_idx (dec.utlb),
        .rd_val (utlb_rd)
    );

    always_comb begin
        t_d.rdata = '0;
        if (rd_any) begin
            if (dec.hit_ctx) begin
                for (int c = 0; c < NUM_CTX; c++)
                    if (dec.ctx == 4'(c)) t_d.rdata = slot_rd[c];
            end else if (dec.hit_utlb) begin
                t_d.rdata = utlb_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bus_rdata = t_q.rdata;
    assign irq       = |slot_irq;

    // no read in the previous cycle means an idle, zero data bus
    assert_idle_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_any) |-> (bus_rdata == 32'b0));

endmodule

// File: tb/test_iommu_ctx_regs.sv
module test_iommu_ctx_regs;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        fault_valid;
    logic [3:0]  fault_ctx;
    logic [4:0]  fault_kind;
    logic [63:0] fault_addr;
    logic [15:0] flush_done;
    logic        irq;

    iommu_ctx_regs i_iommu_ctx_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_valid(fault_valid), .fault_ctx(fault_ctx), .fault_kind(fault_kind),
        .fault_addr(fault_addr), .flush_done(flush_done), .irq(irq)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string tag = "R1";

    // behavioural reference state
    logic        m_en[16], m_ie[16], m_fl[16];
    logic [31:0] m_tcr[16], m_bus[16], m_tlo[16], m_thi[16], m_attr[16];
    logic [4:0]  m_st[16];
    logic [63:0] m_fa[16];
    logic [3:0]  m_uctx[48];
    logic        m_uen[48];
    logic [15:0] m_uid[48];

    function automatic int cbase(input int c);
        return (c < 8) ? c * 64 : 2048 + (c - 8) * 64;
    endfunction

    function automatic int ubase(input int n);
        return (n < 32) ? 768 + 16 * n : 1536 + 16 * (n - 32);
    endfunction

    function automatic int find_ctx(input int a, output int off);
        for (int c = 0; c < 16; c++) begin
            if (a >= cbase(c) && a < cbase(c) + 64) begin
                off = a - cbase(c);
                return c;
            end
        end
        off = 0;
        return -1;
    endfunction

    function automatic int find_utlb(input int a, output int sel);
        for (int n = 0; n < 48; n++) begin
            if (a == ubase(n)) begin sel = 0; return n; end
            if (a == ubase(n) + 8) begin sel = 1; return n; end
        end
        sel = 0;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        int off, sel, c, n;
        c = find_ctx(a, off);
        if (c >= 0) begin
            case (off)
                0:  return {29'b0, m_ie[c], m_fl[c], m_en[c]};
                8:  return m_tcr[c];
                12: return m_bus[c];
                16: return m_tlo[c];
                20: return m_thi[c];
                32: return {27'b0, m_st[c]};
                40: return m_attr[c];
                48: return m_fa[c][31:0];
                52: return m_fa[c][63:32];
                default: return 32'b0;
            endcase
        end
        n = find_utlb(a, sel);
        if (n >= 0) begin
            if (sel == 0) return {24'b0, m_uctx[n], 3'b0, m_uen[n]};
            return {16'b0, m_uid[n]};
        end
        return 32'b0;
    endfunction

    task automatic m_write(input int a, input logic [31:0] d);
        int off, sel, c, n;
        c = find_ctx(a, off);
        if (c >= 0) begin
            case (off)
                0:  begin m_en[c] = d[0]; m_ie[c] = d[2]; if (d[1]) m_fl[c] = 1'b1; end
                8:  m_tcr[c] = d;
                12: m_bus[c] = d;
                16: m_tlo[c] = d;
                20: m_thi[c] = d;
                32: begin m_st[c] = 5'b0; m_fa[c] = 64'b0; end
                40: m_attr[c] = d;
                default: ;
            endcase
        end
        n = find_utlb(a, sel);
        if (n >= 0) begin
            if (sel == 0) begin m_uctx[n] = d[7:4]; m_uen[n] = d[0]; end
            else m_uid[n] = d[15:0];
        end
    endtask

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic step(input logic rq, input logic we, input int a, input logic [31:0] wd,
                        input logic fv, input int fc, input logic [4:0] fk,
                        input logic [63:0] fa, input logic [15:0] dn);
        logic [31:0] exp_rd;
        logic exp_irq;
        logic [4:0] k;
        bus_req = rq; bus_we = we; bus_addr = 12'(a); bus_wdata = wd;
        fault_valid = fv; fault_ctx = 4'(fc); fault_kind = fk; fault_addr = fa;
        flush_done = dn;
        exp_rd = (rq && !we) ? m_read(a) : 32'b0;
        for (int c = 0; c < 16; c++) if (dn[c]) m_fl[c] = 1'b0;
        if (rq && we) m_write(a, wd);
        k = fk & 5'b10111;
        if (fv && k != 5'b0) begin
            if (m_st[fc] == 5'b0) m_fa[fc] = fa;
            m_st[fc] = m_st[fc] | k;
        end
        exp_irq = 1'b0;
        for (int c = 0; c < 16; c++) if (m_ie[c] && m_st[c] != 5'b0) exp_irq = 1'b1;
        @(posedge clk);
        #1;
        chk({tag, " rdata"}, bus_rdata, exp_rd);
        chk({tag, " irq"}, {31'b0, irq}, {31'b0, exp_irq});
    endtask

    task automatic rd(input int a);
        step(1, 0, a, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input int a, input logic [31:0] d);
        step(1, 1, a, d, 0, 0, 0, 0, 0);
    endtask
    task automatic flt(input int c, input logic [4:0] k, input logic [63:0] fa);
        step(0, 0, 0, 0, 1, c, k, fa, 0);
    endtask
    task automatic ack(input logic [15:0] dn);
        step(0, 0, 0, 0, 0, 0, 0, 0, dn);
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int c = 0; c < 16; c++) begin
            m_en[c] = 0; m_ie[c] = 0; m_fl[c] = 0; m_tcr[c] = 0; m_bus[c] = 0;
            m_tlo[c] = 0; m_thi[c] = 0; m_attr[c] = 0; m_st[c] = 0; m_fa[c] = 0;
        end
        for (int n = 0; n < 48; n++) begin m_uctx[n] = 0; m_uen[n] = 0; m_uid[n] = 0; end
        rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        fault_valid = 0; fault_ctx = 0; fault_kind = 0; fault_addr = 0; flush_done = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        tag = "R1";
        rd(cbase(0)); rd(cbase(9) + 32); rd(cbase(15) + 48); rd(ubase(47)); idle();

        // R9 and R10: full words in both windows
        tag = "R9";
        for (int i = 0; i < 4; i++) begin
            int c = (i == 0) ? 0 : (i == 1) ? 7 : (i == 2) ? 8 : 15;
            wr(cbase(c) + 8,  32'hA000_0000 + c);
            wr(cbase(c) + 12, 32'hB000_0000 + c);
            wr(cbase(c) + 16, 32'hC000_0000 + c);
            wr(cbase(c) + 20, 32'hD000_0000 + c);
            wr(cbase(c) + 40, 32'hE000_0000 + c);
        end
        tag = "R10";
        for (int i = 0; i < 4; i++) begin
            int c = (i == 0) ? 0 : (i == 1) ? 7 : (i == 2) ? 8 : 15;
            rd(cbase(c) + 8); rd(cbase(c) + 12); rd(cbase(c) + 16);
            rd(cbase(c) + 20); rd(cbase(c) + 40);
        end
        rd(cbase(1) + 8); rd(cbase(9) + 8);

        // R2 control bits
        tag = "R2";
        wr(cbase(1), 32'hFFFF_FFFD); rd(cbase(1));
        wr(cbase(1), 32'h0000_0001); rd(cbase(1));

        // R3 flush handshake
        tag = "R3";
        wr(cbase(3), 32'h2); rd(cbase(3)); idle(); rd(cbase(3));
        wr(cbase(3), 32'h0); rd(cbase(3));
        ack(16'h0010); rd(cbase(3)); rd(cbase(4));
        ack(16'h0008); rd(cbase(3));
        ack(16'h0008); rd(cbase(3));
        wr(cbase(10), 32'h3); rd(cbase(10));
        step(1, 1, cbase(10), 32'h2, 0, 0, 0, 0, 16'h0400); rd(cbase(10));
        ack(16'h0400); rd(cbase(10));

        // R4, R5, R7 fault capture and interrupt
        tag = "R5";
        wr(cbase(2), 32'h4);
        tag = "R4";
        flt(2, 5'b00001, 64'h0000_0012_3456_7000); rd(cbase(2) + 32);
        tag = "R7";
        flt(2, 5'b10000, 64'h0000_0099_0000_1000);
        rd(cbase(2) + 32); rd(cbase(2) + 48); rd(cbase(2) + 52);
        tag = "R4";
        flt(5, 5'b01000, 64'hFFFF_0000_0000_0001); rd(cbase(5) + 32); rd(cbase(5) + 48);
        flt(5, 5'b11111, 64'h1); rd(cbase(5) + 32);
        tag = "R12";
        wr(cbase(2) + 48, 32'h5555_5555); rd(cbase(2) + 48);

        // R6, R8 clearing
        tag = "R6";
        wr(cbase(2) + 32, 32'h0); rd(cbase(2) + 32);
        tag = "R8";
        rd(cbase(2) + 48); rd(cbase(2) + 52);
        tag = "R6";
        flt(2, 5'b00100, 64'h0000_0001_0000_2000); rd(cbase(2) + 32);
        wr(cbase(2) + 32, 32'h4); rd(cbase(2) + 32); rd(cbase(2) + 48);
        step(1, 1, cbase(2) + 32, 32'h0, 1, 2, 5'b00010, 64'h77, 0);
        rd(cbase(2) + 32); rd(cbase(2) + 48);
        wr(cbase(2) + 32, 32'h0); wr(cbase(5) + 32, 32'h0); idle();

        // R5 interrupt enable gating
        tag = "R5";
        flt(6, 5'b00010, 64'h0000_0000_0000_6000); idle();
        wr(cbase(6), 32'h4); idle();
        wr(cbase(6), 32'h0); idle();
        wr(cbase(6), 32'h4); wr(cbase(6) + 32, 32'h0); idle();

        // R11 micro-TLB words
        tag = "R11";
        wr(ubase(0), 32'h0000_00A3); rd(ubase(0));
        wr(ubase(0) + 8, 32'h1234_5678); rd(ubase(0) + 8);
        wr(ubase(33), 32'hFFFF_FF71); rd(ubase(33)); rd(ubase(31));
        wr(ubase(47) + 8, 32'h0000_BEEF); rd(ubase(47) + 8);
        wr(ubase(33), 32'h0); rd(ubase(33));

        // R12 unmapped addresses
        tag = "R12";
        for (int i = 0; i < 7; i++) begin
            int a = (i == 0) ? 12'h004 : (i == 1) ? 12'h200 : (i == 2) ? 12'h304 :
                    (i == 3) ? 12'h500 : (i == 4) ? 12'h7F0 : (i == 5) ? 12'hC00 : 12'hFFC;
            wr(a, 32'hDEAD_BEEF); rd(a);
        end
        rd(cbase(0) + 8); rd(ubase(0));

        // R13 latency: read followed by idle
        tag = "R13";
        rd(cbase(15) + 8); idle(); idle();

        // mixed traffic
        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            int c = $urandom_range(15);
            int sel = $urandom_range(9);
            int offs = (sel < 3) ? 0 : (sel < 5) ? 32 : (sel == 5) ? 48 : (sel == 6) ? 52 : 8;
            logic [15:0] dn = ($urandom_range(3) == 0) ? 16'(1 << $urandom_range(15)) : 16'h0;
            step($urandom_range(1) == 1, $urandom_range(1) == 1, cbase(c) + offs,
                 ($urandom_range(1) == 1) ? 32'h6 : 32'(i),
                 $urandom_range(2) == 0, $urandom_range(15), 5'($urandom_range(31)),
                 {32'(i), 32'($urandom)}, dn);
        end

        summary();
    end
endmodule